// File: doc/BRIEF.md
# Receive Frame-Word Hunter and Message Deframer

This block sits behind a bit-recovery stage. It takes one received bit per strobe and looks for either of two 16-bit frame words. When it finds one, it raises that word's detect flag. It then groups the bits that follow into bytes and hands each byte to a host read register. Each message is eight bytes: six payload bytes followed by two check bytes.

A serial checksum checker runs over the 64 message bits. Its verdict is presented with the data-ready event of the final check byte. While a message is in progress, the hunt for frame words is switched off. At the end of each message, a host control input decides what happens next. The receiver either treats the next eight bytes as another checked message, or goes back to hunting for a frame word.

The host sees byte-level flags. Data-ready and checksum-good are released by a status read followed by a data read. The detect flags are released by a status read alone. A sticky overrun flag records a byte that was overwritten before the host read it. Dropping the receive enable clears everything and restarts the hunt.

Top module: `rx_frame_deframer`

## Requirements
- R1: The frame words are 0xC4D7 (first word) and 0x3B28 (second word), compared MSB-first against the last 16 strobed bits with no bit errors allowed. `sync_seen` (first word) or `synt_seen` (second word) rises in the cycle after the strobe that carries the 16th bit, and not after the 15th.
- R2: While `rx_en` is high, `data_rdy` never rises before a frame word has been detected. While `rx_en` is low, strobed bits are ignored entirely.
- R3: Within each byte, the first bit received is placed in bit 7 of `rx_byte` and the last bit in bit 0.
- R4: After a frame word, exactly eight bytes are delivered. `chk_good` can be high only while `data_rdy` is high, and it is low for the first seven bytes.
- R5: The check covers the 64 message bits in arrival order. Bits 1 to 63 are divided modulo 2 by x^15+x^14+x^13+x^11+x^4+x^2+1, with bit 63 inverted before it enters the divider. Even parity is taken over bits 1 to 63 as received. `chk_good` is 1 with the eighth byte only if the remainder is zero and the parity equals bit 64.
- R6: While a message is in progress, neither detect flag is raised, even if the payload contains a frame word.
- R7: `msg_cont` is sampled on the strobe of the 64th bit. If it is 1, the next 64 bits form another checked message without a frame word. If it is 0, no further bytes are delivered until a new frame word arrives.
- R8: `data_rdy` and `chk_good` clear only when a `stat_rd` pulse is followed by a `data_rd` pulse after the byte arrived. A `data_rd` on its own leaves them set.
- R9: `sync_seen` and `synt_seen` clear on a `stat_rd` pulse.
- R10: With `rx_en` low, `data_rdy`, `chk_good`, `sync_seen`, `synt_seen`, `overrun` and `rx_byte` are all 0, and the receiver returns to hunting.
- R11: If a byte completes while `data_rdy` is still set, the new byte replaces the old one and `overrun` sets and stays set until `rx_en` falls.
- R12: A frame word is recognised only if all 16 of its bits were received since hunting last began, that is, since `rx_en` rose or a message ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low clears flags and restarts the hunt |
| bit_stb | input | 1 | One-cycle strobe qualifying `bit_in` |
| bit_in | input | 1 | Recovered serial bit |
| msg_cont | input | 1 | 1: continue with another message after the current one; 0: re-hunt |
| stat_rd | input | 1 | One-cycle pulse: host read the status |
| data_rd | input | 1 | One-cycle pulse: host read the data byte |
| rx_byte | output | 8 | Last delivered byte |
| data_rdy | output | 1 | A byte is waiting |
| chk_good | output | 1 | Checksum verdict, valid with the eighth byte |
| sync_seen | output | 1 | First frame word detected |
| synt_seen | output | 1 | Second frame word detected |
| overrun | output | 1 | Sticky: a byte was overwritten unread |

## Verification
The bench feeds a frame word that contains a partial match one bit early. A detector that fired on 15 bits, or that confused the two complementary words, would raise the wrong flag. Payloads that carry both frame words verify that a design still hunting mid-message would raise a flag. Valid codewords, and codewords corrupted in either a remainder bit or the parity bit, catch a checker that forgets the bit-63 inversion, takes odd parity, or reports its verdict on the wrong byte.

Other tests target the host side and the message boundaries:
- Reversed byte order would show up as a wrong `rx_byte`.
- A read sequence that accepts a lone data read would clear `data_rdy` too early.
- A missed `msg_cont` sample would deliver extra bytes or drop the follow-on message.
- Half a frame word split across an enable toggle verifies that a hunter which keeps stale bits would lock falsely.

// File: rtl/rxdf_pkg.sv
// Package: shared constants and types for the receive frame-word deframer.
// Assumes MSB-first transmission of frame words and message bytes.
package rxdf_pkg;
    localparam int FW_W      = 16;
    localparam logic [FW_W-1:0] WORD_A = 16'hC4D7;
    localparam logic [FW_W-1:0] WORD_B = 16'h3B28;
    localparam int BYTE_W    = 8;
    localparam int MSG_BYTES = 6;
    localparam int CHK_BYTES = 2;
    localparam int CHK_W     = 15;
    localparam logic [CHK_W-1:0] CHK_POLY = 15'h6815;  // low terms of the divisor

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_MSG  = 1'b1
    } rx_state_t;
endpackage

// File: rtl/rxdf_hunt.sv
// Module: frame-word hunter.
// Shifts every qualified bit into a window and reports an exact match against
// either frame word. A match only counts once W bits have been received since
// the last clear, so stale bits never combine with fresh ones.
// Assumes: bit_stb is already gated by the receive enable.
module rxdf_hunt #(
    parameter int               W      = 16,
    parameter logic [W-1:0]     WORD_A = '0,
    parameter logic [W-1:0]     WORD_B = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_stb,
    input  logic bit_in,
    output logic hit_a,
    output logic hit_b
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W - 1);

    logic [W-1:0]     win_q;
    logic [W-1:0]     win_nxt;
    logic [CNT_W-1:0] fill_q;
    logic             armed;

    // Next window contents and match decode for this strobe.
    always_comb begin
        win_nxt = {win_q[W-2:0], bit_in};
        armed   = bit_stb && !clr && (fill_q == FULL);
        hit_a   = armed && (win_nxt == WORD_A);
        hit_b   = armed && (win_nxt == WORD_B);
    end

    // Window shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_stb) begin
            win_q <= win_nxt;
        end
    end

    // Count fresh bits since the last clear, saturating at W-1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill_q <= '0;
        end else if (bit_stb && fill_q != FULL) begin
            fill_q <= fill_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxdf_chk.sv
// Module: serial checksum checker.
// Divides the first TOTAL_BITS-1 message bits (with the second-to-last one
// inverted) by the generator, and keeps even parity over the same bits.
// On the final bit, ok is high when the remainder is zero and the parity matches.
// Assumes: bit_idx counts 0..TOTAL_BITS-1 within a message.
module rxdf_chk #(
    parameter int               TOTAL_BITS = 64,
    parameter int               IDX_W      = 6,
    parameter int               CW         = 15,
    parameter logic [CW-1:0]    POLY       = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_stb,
    input  logic             bit_in,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             ok
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL_BITS - 1);
    localparam logic [IDX_W-1:0] FLIP = IDX_W'(TOTAL_BITS - 2);

    logic [CW-1:0] rem_q;
    logic [CW-1:0] rem_nxt;
    logic          par_q;
    logic          b_eff;

    // One division step; the verdict is formed against the final bit.
    always_comb begin
        b_eff   = (bit_idx == FLIP) ? ~bit_in : bit_in;
        rem_nxt = {rem_q[CW-2:0], b_eff} ^ (rem_q[CW-1] ? POLY : '0);
        ok      = (rem_q == '0) && (par_q == bit_in);
    end

    // Divider and parity state, restarted at each message boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem_q <= '0;
            par_q <= 1'b0;
        end else if (bit_stb) begin
            if (bit_idx == LAST) begin
                rem_q <= '0;
                par_q <= 1'b0;
            end else begin
                rem_q <= rem_nxt;
                par_q <= par_q ^ bit_in;
            end
        end
    end

    // R5: every message starts with a clean divider and parity.
    p_clean_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !clr && bit_idx == '0) |-> (rem_q == '0 && !par_q));
endmodule

// File: rtl/rxdf_frame.sv
// Module: message framer.
// After a frame-word hit, counts TOTAL_BITS bits and assembles them MSB-first
// into bytes. At the last bit it samples msg_cont and either stays in the
// message phase or returns to hunting.
// Assumes: bit_stb is already gated by the receive enable.
module rxdf_frame #(
    parameter int TOTAL_BITS = 64,
    parameter int BYTE_W     = 8,
    parameter int IDX_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              word_hit,
    input  logic              msg_cont,
    output logic              in_msg,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              msg_end
);
    import rxdf_pkg::*;

    localparam int SUB_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL_BITS - 1);

    rx_state_t         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-2:0] asm_q;

    // Byte completion and message-end decode.
    always_comb begin
        in_msg    = (state_q == ST_MSG);
        bit_idx   = idx_q;
        byte_val  = {asm_q, bit_in};
        byte_done = bit_stb && in_msg && (idx_q[SUB_W-1:0] == '1);
        msg_end   = bit_stb && in_msg && (idx_q == LAST);
    end

    // Phase, bit index and partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
            asm_q   <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (word_hit) begin
                        state_q <= ST_MSG;
                        idx_q   <= '0;
                    end
                end
                ST_MSG: begin
                    if (bit_stb) begin
                        asm_q <= byte_val[BYTE_W-2:0];
                        if (idx_q == LAST) begin
                            idx_q <= '0;
                            if (!msg_cont) state_q <= ST_HUNT;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R7: a message end with continuation restarts the message at bit 0.
    p_cont_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && msg_cont && rx_en) |=> (in_msg && bit_idx == '0));
    // R7: a message end without continuation returns to hunting.
    p_stop_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_end && !msg_cont) |=> !in_msg);
endmodule

// File: rtl/rx_frame_deframer.sv
// Module: receive frame-word detector and deframer (top).
// Ties together the hunter, the framer and the checker, and holds the
// host-visible byte register and flags.
// Assumes: stat_rd and data_rd are single-cycle pulses from the host side.
module rx_frame_deframer #(
    parameter int                        FW_W      = rxdf_pkg::FW_W,
    parameter logic [FW_W-1:0]           WORD_A    = rxdf_pkg::WORD_A,
    parameter logic [FW_W-1:0]           WORD_B    = rxdf_pkg::WORD_B,
    parameter int                        BYTE_W    = rxdf_pkg::BYTE_W,
    parameter int                        MSG_BYTES = rxdf_pkg::MSG_BYTES,
    parameter int                        CHK_BYTES = rxdf_pkg::CHK_BYTES,
    parameter int                        CHK_W     = rxdf_pkg::CHK_W,
    parameter logic [CHK_W-1:0]          CHK_POLY  = rxdf_pkg::CHK_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              msg_cont,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              data_rdy,
    output logic              chk_good,
    output logic              sync_seen,
    output logic              synt_seen,
    output logic              overrun
);
    localparam int TOTAL_BITS = (MSG_BYTES + CHK_BYTES) * BYTE_W;
    localparam int IDX_W      = $clog2(TOTAL_BITS);

    logic              stb_q;
    logic              hit_a, hit_b;
    logic              in_msg;
    logic [IDX_W-1:0]  bit_idx;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              msg_end;
    logic              chk_ok;
    logic              stat_arm;

    // Strobes only count while the receiver is enabled.
    assign stb_q = bit_stb && rx_en;

    rxdf_hunt #(.W(FW_W), .WORD_A(WORD_A), .WORD_B(WORD_B)) u_hunt (
        .clk(clk), .rst_n(rst_n), .clr(!rx_en || in_msg),
        .bit_stb(stb_q), .bit_in(bit_in), .hit_a(hit_a), .hit_b(hit_b)
    );

    rxdf_frame #(.TOTAL_BITS(TOTAL_BITS), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(stb_q), .bit_in(bit_in),
        .word_hit(hit_a || hit_b), .msg_cont(msg_cont), .in_msg(in_msg),
        .bit_idx(bit_idx), .byte_done(byte_done), .byte_val(byte_val), .msg_end(msg_end)
    );

    rxdf_chk #(.TOTAL_BITS(TOTAL_BITS), .IDX_W(IDX_W), .CW(CHK_W), .POLY(CHK_POLY)) u_chk (
        .clk(clk), .rst_n(rst_n), .clr(!rx_en || !in_msg), .bit_stb(stb_q),
        .bit_in(bit_in), .bit_idx(bit_idx), .ok(chk_ok)
    );

    // Frame-word detect flags: set on a hit, released by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            sync_seen <= 1'b0;
            synt_seen <= 1'b0;
        end else begin
            sync_seen <= hit_a || (sync_seen && !stat_rd);
            synt_seen <= hit_b || (synt_seen && !stat_rd);
        end
    end

    // Remember a status read that saw a pending byte, so a data read can release it.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            stat_arm <= 1'b0;
        end else if (byte_done || data_rd) begin
            stat_arm <= 1'b0;
        end else if (stat_rd && data_rdy) begin
            stat_arm <= 1'b1;
        end
    end

    // Byte register, data-ready, checksum verdict and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            rx_byte  <= '0;
            data_rdy <= 1'b0;
            chk_good <= 1'b0;
            overrun  <= 1'b0;
        end else if (byte_done) begin
            rx_byte  <= byte_val;
            data_rdy <= 1'b1;
            chk_good <= msg_end && chk_ok;
            if (data_rdy) overrun <= 1'b1;
        end else if (data_rd && stat_arm) begin
            data_rdy <= 1'b0;
            chk_good <= 1'b0;
        end
    end

    // R10: a low enable leaves every flag clear in the next cycle.
    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!data_rdy && !chk_good && !sync_seen && !synt_seen && !overrun));
    // R4: the checksum verdict is never shown without a pending byte.
    p_good_needs_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_good |-> data_rdy);
    // R2: a new byte only appears after a qualified bit strobe.
    p_rdy_from_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy) |-> $past(bit_stb && rx_en));
    // R6: no frame-word hit while a message is being received.
    p_no_hunt_in_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_msg |-> !(hit_a || hit_b));
    // R11: overrun stays set while the receiver stays enabled.
    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overrun) && $past(rx_en) && rx_en) |-> overrun);
    // R9: a detect flag holds until a status read.
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_seen) && $past(rx_en) && !$past(stat_rd)) |-> sync_seen);
endmodule

// File: tb/rx_frame_deframer_test.sv
`timescale 1ns/1ps
module rx_frame_deframer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, bit_stb = 1'b0, bit_in = 1'b0, msg_cont = 1'b0;
    logic       stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       data_rdy, chk_good, sync_seen, synt_seen, overrun;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_frame_deframer uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(bit_stb), .bit_in(bit_in),
        .msg_cont(msg_cont), .stat_rd(stat_rd), .data_rd(data_rd), .rx_byte(rx_byte),
        .data_rdy(data_rdy), .chk_good(chk_good), .sync_seen(sync_seen),
        .synt_seen(synt_seen), .overrun(overrun)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Codeword from 48 payload bits by long division (first bit = MSB).
    function automatic logic [63:0] codeword(input logic [47:0] m);
        logic [62:0] v;
        logic [14:0] r;
        logic        p;
        v = {m, 15'b0};
        for (int i = 62; i >= 15; i--)
            if (v[i]) v[i -: 16] = v[i -: 16] ^ 16'hE815;
        r    = v[14:0];
        r[0] = ~r[0];
        p    = ^{m, r};
        return {m, r, p};
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_stb = 1'b1;
        @(negedge clk); bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic host_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
    endtask

    // Deliver one 8-byte message, checking each byte and the verdict on the last.
    task automatic take_msg(input logic [63:0] cw, input logic good);
        for (int k = 0; k < 8; k++) begin
            send_byte(cw[63 - 8*k -: 8]);
            check("R3", "byte value", rx_byte, cw[63 - 8*k -: 8]);
            check("R4", "data ready per byte", data_rdy, 1'b1);
            if (k == 7) check("R5", "checksum verdict", chk_good, good);
            else if (k == 0 || k == 5) check("R4", "verdict low before last", chk_good, 1'b0);
            host_read();
        end
    endtask

    task automatic t_reset();
        check("R10", "reset flags", {data_rdy, chk_good, sync_seen, synt_seen, overrun}, 5'b0);
        check("R10", "reset byte", rx_byte, 8'h00);
    endtask

    task automatic t_detect_and_clear();
        restart();
        send_word(16'h0000);
        send_bit(1'b1);                       // leading partial match
        for (int i = 15; i >= 1; i--) send_bit(rxdf_pkg::WORD_A[i]);
        check("R1", "no flag after 15 bits", {sync_seen, synt_seen}, 2'b00);
        send_bit(rxdf_pkg::WORD_A[0]);
        check("R1", "first word flag on 16th bit", {sync_seen, synt_seen}, 2'b10);
        check("R2", "no byte yet", data_rdy, 1'b0);
        @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        check("R9", "flag cleared by status read", sync_seen, 1'b0);
    endtask

    task automatic t_ignore_and_hunt();
        restart();
        send_word(16'hAAAA); send_word(16'h0F0F);
        check("R2", "no byte before frame word", data_rdy, 1'b0);
        @(negedge clk); rx_en = 1'b0;
        send_word(rxdf_pkg::WORD_A);
        check("R2", "bits ignored while disabled", {sync_seen, data_rdy}, 2'b00);
        @(negedge clk); rx_en = 1'b1;
        send_byte(8'hC4);
        restart();
        send_byte(8'hD7);
        check("R12", "split word not accepted", {sync_seen, synt_seen}, 2'b00);
    endtask

    task automatic t_single_msg();
        logic [63:0] cw;
        cw = codeword(48'hC4D7_3B28_5A3C);
        restart();
        msg_cont = 1'b0;
        send_word(16'hAAAA);
        send_word(rxdf_pkg::WORD_A);
        check("R1", "first word detected", sync_seen, 1'b1);
        take_msg(cw, 1'b1);
        check("R6", "payload words not detected", {sync_seen, synt_seen}, 2'b00);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'hFF);
        check("R7", "no bytes after stop", data_rdy, 1'b0);
    endtask

    task automatic t_bad_msgs();
        logic [63:0] cw;
        cw = codeword(48'h1234_5678_9ABC) ^ 64'h0000_0000_0000_0100;
        restart(); msg_cont = 1'b0;
        send_word(rxdf_pkg::WORD_B);
        check("R1", "second word detected", {sync_seen, synt_seen}, 2'b01);
        take_msg(cw, 1'b0);
        cw = codeword(48'h0F1E_2D3C_4B5A) ^ 64'h1;
        send_word(rxdf_pkg::WORD_B);
        take_msg(cw, 1'b0);
    endtask

    task automatic t_continue();
        restart(); msg_cont = 1'b1;
        send_word(rxdf_pkg::WORD_B);
        take_msg(codeword(48'hFEDC_BA98_7654), 1'b1);
        take_msg(codeword(48'h0000_0000_0001), 1'b1);
        check("R7", "continued message delivered", data_rdy, 1'b0);
        msg_cont = 1'b0;
        take_msg(codeword(48'h8000_0000_0000), 1'b1);
        send_byte(8'h00);
        check("R7", "stopped after cleared control", data_rdy, 1'b0);
    endtask

    task automatic t_read_order_overrun();
        restart(); msg_cont = 1'b0;
        send_word(rxdf_pkg::WORD_A);
        send_byte(8'h81);
        @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
        check("R8", "data read alone keeps ready", data_rdy, 1'b1);
        send_byte(8'h3C);
        check("R11", "overrun set", overrun, 1'b1);
        check("R11", "newer byte kept", rx_byte, 8'h3C);
        host_read();
        check("R8", "status then data clears ready", data_rdy, 1'b0);
        check("R11", "overrun sticky", overrun, 1'b1);
        @(negedge clk); rx_en = 1'b0; @(negedge clk);
        check("R10", "disable clears flags", {data_rdy, chk_good, sync_seen, synt_seen, overrun}, 5'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_detect_and_clear();
        t_ignore_and_hunt();
        t_single_msg();
        t_bad_msgs();
        t_continue();
        t_read_order_overrun();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule